// File: doc/BRIEF.md
# Periodic Framed Byte Serializer

This block turns a fixed-length byte frame into a continuous serial bit stream for a downstream modulator. A free-running external bit clock is brought into the system clock domain as a one-cycle enable, `bit_en`. Each cycle with `bit_en` high is one "tick", and the block moves its output by exactly one bit on each tick. A frame holds `FRAME_BYTES` bytes (60 by default):

- position 0 is the high sync byte 0xEB;
- position 1 is the low sync byte 0x90;
- positions 2 to 58 are payload taken from a writable buffer;
- position 59 is a trailer byte 0x00.

Every byte goes out most significant bit first and occupies 8 ticks.

Frame starts recur every `PERIOD` ticks (500 by default). The 60 framed bytes use 480 ticks. The remaining 20 ticks are filled with a repeating idle byte (0x00). The idle byte that is in flight when the period wraps is abandoned after 4 bits, and the next frame begins at once. Nothing is sent until the first full period after reset has elapsed.

An active-low strobe `load_n` marks each byte start. The payload buffer is double-buffered: a write becomes visible only at the next frame boundary, so no frame ever mixes old and new payload.

Top module: `frame_serializer`

## Requirements
- R1: While `rst` is high, and after it until the first frame starts, `ser_out` is 0 and `load_n` is 1.
- R2: The first frame starts on the 500th tick after reset is released; ticks 1 to 499 send nothing and raise no strobe.
- R3: A frame starts on every 500th tick after the first. On that tick the counter wraps to zero, and the first 16 bits out are 0xEB then 0x90.
- R4: Frame position 2+k carries payload byte k, for k in 0 to 56. Payload write address k selects that byte. After reset every payload byte is 0x00.
- R5: Frame position 59 is the trailer byte 0x00.
- R6: Each byte is sent MSB first, one bit per tick, 8 ticks per byte. Frame tick p carries bit 7-(p mod 8) of frame byte p/8.
- R7: `load_n` is 0 for exactly the tick period that starts each byte (frame tick p with p mod 8 = 0) and 1 otherwise. It is never low on two consecutive ticks.
- R8: Frame ticks 480 to 499 carry the idle byte 0x00. The idle byte started at tick 496 is cut after 4 bits, and the next tick is the MSB of 0xEB.
- R9: A payload write made before a frame boundary tick appears from that frame on, and never in the frame in progress. A write in the same cycle as a boundary tick lands in the frame after it.
- R10: Payload writes with an address of 57 or above are ignored.
- R11: `ser_out` and `load_n` change only in cycles with `bit_en` high (or under reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle pulse per serial bit period |
| wr_en | input | 1 | Payload write enable |
| wr_addr | input | ADDR_W (6) | Payload byte index, 0 to 56 valid |
| wr_data | input | 8 | Payload byte value |
| ser_out | output | 1 | Serial data, MSB first, registered |
| load_n | output | 1 | Byte-start strobe, active low, registered |

## Verification
Both outputs are registered: they take the value for tick n on the rising edge that samples the nth `bit_en`. The bench updates its reference tick count at that edge and compares at the next falling edge. In cycles between ticks it expects both outputs to hold. A payload write is applied to the reference's pending copy in the cycle it is driven, and copied to the live copy only on the next boundary tick. Writes placed mid-frame, including ones aimed at positions still to come in that frame, must therefore show up exactly one frame later. The first sync bit is due on the 500th tick, and the cut idle byte is followed by the sync MSB on the very next tick.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;
  localparam int BYTE_BITS = 8;
  typedef logic [BYTE_BITS-1:0] byte_t;
endpackage

// File: rtl/frame_timer.sv
module frame_timer #(
  parameter int PERIOD = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  output logic frame_start,
  output logic started
);
  localparam int CW = $clog2(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt;

  assign frame_start = bit_en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      started <= 1'b0;
    end else if (bit_en) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (frame_start) started <= 1'b1;
    end
  end

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cnt == '0 && started));
endmodule

// File: rtl/payload_bank.sv
module payload_bank
  import frame_ser_pkg::*;
#(
  parameter int    N_PAY  = 57,
  parameter int    ADDR_W = 6,
  parameter byte_t FILL   = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  byte_t             wr_data,
  input  logic              commit,
  input  logic [ADDR_W-1:0] rd_idx,
  output byte_t             rd_data
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(N_PAY - 1);

  logic [N_PAY-1:0][BYTE_BITS-1:0] pend;
  logic [N_PAY-1:0][BYTE_BITS-1:0] live;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= {N_PAY{FILL}};
      live <= {N_PAY{FILL}};
    end else begin
      if (commit) live <= pend;
      if (wr_en && wr_addr <= TOP) pend[wr_addr] <= wr_data;
    end
  end

  assign rd_data = (rd_idx <= TOP) ? live[rd_idx] : FILL;

  // R9
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(live));
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter
  import frame_ser_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  parameter int IW          = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          frame_start,
  input  logic          started,
  input  byte_t         next_byte,
  output logic [IW-1:0] byte_idx,
  output logic          ser_out,
  output logic          load_n
);
  localparam int PW = $clog2(BYTE_BITS);
  localparam logic [IW-1:0] END_IDX = IW'(FRAME_BYTES);

  logic [PW-1:0] bitpos;
  byte_t         shreg;
  logic          take;

  assign take = frame_start || (started && bit_en && bitpos == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitpos   <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      ser_out  <= 1'b0;
      load_n   <= 1'b1;
    end else if (take) begin
      shreg    <= {next_byte[BYTE_BITS-2:0], 1'b0};
      ser_out  <= next_byte[BYTE_BITS-1];
      load_n   <= 1'b0;
      bitpos   <= PW'(1);
      if (frame_start)            byte_idx <= IW'(1);
      else if (byte_idx != END_IDX) byte_idx <= byte_idx + 1'b1;
    end else if (started && bit_en) begin
      shreg   <= {shreg[BYTE_BITS-2:0], 1'b0};
      ser_out <= shreg[BYTE_BITS-1];
      load_n  <= 1'b1;
      bitpos  <= bitpos + 1'b1;
    end
  end

  // R7
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !load_n) |=> load_n);
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frame_ser_pkg::*;
#(
  parameter int    FRAME_BYTES = 60,
  parameter int    PERIOD      = 500,
  parameter int    ADDR_W      = 6,
  parameter byte_t SYNC_HI     = 8'hEB,
  parameter byte_t SYNC_LO     = 8'h90,
  parameter byte_t TRAILER     = 8'h00,
  parameter byte_t IDLE        = 8'h00,
  parameter byte_t FILL        = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              ser_out,
  output logic              load_n
);
  localparam int PAY_BYTES = FRAME_BYTES - 3;
  localparam int IW        = $clog2(FRAME_BYTES + 1);

  logic          frame_start;
  logic          started;
  logic [IW-1:0] byte_idx;
  logic [IW-1:0] sel_idx;
  logic [ADDR_W-1:0] pay_idx;
  byte_t         pay_byte;
  byte_t         next_byte;

  frame_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst(rst), .bit_en(bit_en),
    .frame_start(frame_start), .started(started)
  );

  assign sel_idx = frame_start ? '0 : byte_idx;
  assign pay_idx = ADDR_W'(sel_idx - IW'(2));

  payload_bank #(.N_PAY(PAY_BYTES), .ADDR_W(ADDR_W), .FILL(FILL)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(frame_start),
    .rd_idx(pay_idx), .rd_data(pay_byte)
  );

  always_comb begin
    if (sel_idx == IW'(0))                    next_byte = SYNC_HI;
    else if (sel_idx == IW'(1))               next_byte = SYNC_LO;
    else if (sel_idx == IW'(FRAME_BYTES - 1)) next_byte = TRAILER;
    else if (sel_idx >= IW'(FRAME_BYTES))     next_byte = IDLE;
    else                                      next_byte = pay_byte;
  end

  byte_shifter #(.FRAME_BYTES(FRAME_BYTES), .IW(IW)) u_shift (
    .clk(clk), .rst(rst), .bit_en(bit_en), .frame_start(frame_start),
    .started(started), .next_byte(next_byte), .byte_idx(byte_idx),
    .ser_out(ser_out), .load_n(load_n)
  );

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(ser_out) && $stable(load_n)));

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !started |-> (ser_out == 1'b0 && load_n));

  // R3
  sync_msb_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (!load_n && ser_out == SYNC_HI[7]));
endmodule

// File: tb/test_frame_serializer.sv
module test_frame_serializer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic ser_out, load_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int n = 0;
  int pend[57];
  int live[57];
  logic exp_ser = 1'b0;
  logic exp_ld = 1'b1;
  string tag_s = "R1";
  string tag_l = "R1";

  always #4 clk = ~clk;

  frame_serializer i_frame_serializer (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_out(ser_out), .load_n(load_n)
  );

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s at tick %0d: got=%b exp=%b", tag, what, n, got, exp);
    end
  endtask

  function automatic int frame_val(input int j);
    if (j == 0) return 8'hEB;       // R3
    if (j == 1) return 8'h90;       // R3
    if (j == 59) return 8'h00;      // R5 trailer
    if (j >= 60) return 8'h00;      // R8 idle fill
    return live[j-2];               // R4 payload
  endfunction

  task automatic step(input bit en, input bit we, input int addr, input int data);
    int p, j, b, v;
    bit_en  = en;
    wr_en   = we;
    wr_addr = addr[5:0];
    wr_data = data[7:0];
    @(posedge clk);
    if (en) begin
      n++;
      if (n >= 500 && (n - 500) % 500 == 0)
        for (int k = 0; k < 57; k++) live[k] = pend[k];   // R9 commit at boundary
    end
    if (we && addr < 57) pend[addr] = data;               // R10: >= 57 dropped
    if (en) begin
      if (n < 500) begin
        exp_ser = 1'b0; exp_ld = 1'b1;
        tag_s = "R1 R2"; tag_l = "R1 R2";
      end else begin
        p = (n - 500) % 500;
        j = p / 8;
        b = p % 8;
        v = frame_val(j);
        exp_ser = v[7-b];
        exp_ld  = (b != 0);
        if (j < 2)        tag_s = "R3 R6";
        else if (j < 59)  tag_s = "R4 R9 R10 R6";
        else if (j == 59) tag_s = "R5";
        else              tag_s = "R8";
        tag_l = "R7";
      end
    end else begin
      tag_s = "R11"; tag_l = "R11";
    end
    @(negedge clk);
    check(tag_s, "ser_out", ser_out, exp_ser);
    check(tag_l, "load_n", load_n, exp_ld);
  endtask

  initial begin
    for (int k = 0; k < 57; k++) begin pend[k] = 0; live[k] = 0; end
    repeat (3) @(negedge clk);
    bit_en = 1'b1;
    @(negedge clk);
    check("R1", "reset ser_out", ser_out, 1'b0);
    check("R1", "reset load_n", load_n, 1'b1);
    rst = 1'b0;
    bit_en = 1'b0;
    for (int i = 0; i < 2600; i++) begin
      step(1'b1, 1'b0, 0, 0);
      case (n)
        700:  step(1'b0, 1'b1, 0, 8'hA5);   // R9 mid-frame write
        710:  step(1'b0, 1'b1, 56, 8'h3C);
        720:  step(1'b0, 1'b1, 40, 8'h81);  // position still ahead in frame
        730:  step(1'b0, 1'b1, 57, 8'h77);  // R10 ignored address
        740:  step(1'b0, 1'b1, 63, 8'h11);  // R10 ignored address
        1300: step(1'b0, 1'b1, 0, 8'h5A);
        1499: step(1'b0, 1'b1, 5, 8'hC3);   // just before boundary
        1800: step(1'b0, 1'b1, 1, 8'hF0);
        default: step(1'b0, 1'b0, 0, 0);
      endcase
      if (i % 5 == 0) step(1'b0, 1'b0, 0, 0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1-all: got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule